// File: doc/BRIEF.md
# Serial flash write-protection controller

This block keeps the protection state of a serial flash status register and rules on every write-type command before it reaches the array or the status register. The state is four bits: a status-write lock bit, a two-bit protected-range selector, and a write-enable latch. Commands arrive already decoded as a strobe with a three-bit code, together with the candidate status byte and a 16-bit target address. For each command the block returns a one-cycle accept or reject pulse and updates its state in the same cycle.

Status writes are gated by two things. The write-enable latch is a software gate. The lock bit combined with the active-low write-protect pin is a hardware gate. When the lock bit is set and the pin is low, the block is in its hardware-locked mode. In that mode the lock bit and range selector cannot change, so the protected range of the array is also fixed. Page program and block erase are checked against the protected range. Chip erase is refused whenever any part of the array is protected.

Top module: `spi_flash_wp_ctrl`

## Requirements
- R1: After reset the write-enable latch is 0, the lock bit and range selector equal the parameters RST_SRWD and RST_BP, and accept and reject are both 0.
- R2: Write enable (code 1) is always accepted and sets the latch. Write disable (code 2) is always accepted and clears the latch.
- R3: A status write (code 3) with the latch clear is rejected and leaves the lock bit and range selector unchanged.
- R4: A status write with the latch set, while the lock bit is 0 or wp_n is 1, is accepted. It loads the lock bit from new_status[7] and the range selector from new_status[3:2]. All other bits of new_status are ignored.
- R5: prot_mode is 1 exactly when the lock bit is 1 and wp_n is 0. This holds whether the lock bit was set before or after the pin went low. Driving wp_n high leaves the mode at once.
- R6: While prot_mode is 1, every status write is rejected even with the latch set, and the lock bit and range selector keep their values.
- R7: The range selector protects addresses as follows: 00 none, 01 addresses 0xC000 and above, 10 addresses 0x8000 and above, 11 all addresses. A page program (code 4) or block erase (code 5) with the latch set is rejected inside the protected range and accepted outside it.
- R8: Page program, block erase and chip erase are rejected when the latch is clear.
- R9: Chip erase (code 6) is rejected when the range selector is non-zero and accepted when it is 00 and the latch is set.
- R10: After any status write, page program, block erase or chip erase, whether accepted or rejected, the latch is 0.
- R11: For codes 1 to 6, exactly one of accept and reject is high for the single cycle after the strobe. Code 0, code 7, and cycles without a strobe give neither and change no state.
- R12: The status output carries the lock bit in bit 7, the range selector in bits 3:2 and the latch in bit 1. Bits 6:4 and bit 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin, active low, already synchronized |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_code | input | 3 | Command code (1 write enable, 2 write disable, 3 status write, 4 page program, 5 block erase, 6 chip erase) |
| new_status | input | 8 | Candidate status byte for a status write |
| addr | input | 16 | Target address for page program and block erase |
| accept | output | 1 | Command accepted, pulses the cycle after the strobe |
| reject | output | 1 | Command rejected, pulses the cycle after the strobe |
| prot_mode | output | 1 | 1 in hardware-locked mode, 0 in software-protected mode |
| status | output | 8 | Current status register value |

## Verification
The accept and reject pulses and the new status value all come from registers loaded on the clock edge that samples the strobe. The bench therefore drives each command on a falling edge, lets one rising edge pass, and reads these results on the next falling edge, before they clear. prot_mode is combinational from the pin and the lock bit. Its checks are made a short delay after wp_n changes, with no clock edge in between. This covers both orders of entering the hardware-locked mode and the exit through the pin.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_WREN  = 3'd1,
        CMD_WRDI  = 3'd2,
        CMD_WRSR  = 3'd3,
        CMD_PROG  = 3'd4,
        CMD_BERS  = 3'd5,
        CMD_CERS  = 3'd6,
        CMD_RSVD  = 3'd7
    } wp_cmd_t;

    typedef struct packed {
        logic       lock;
        logic [1:0] range;
        logic       wel;
    } wp_state_t;

    localparam int STAT_LOCK_BIT = 7;
    localparam int STAT_RNG_HI   = 3;
    localparam int STAT_RNG_LO   = 2;
    localparam int STAT_WEL_BIT  = 1;

    function automatic logic [7:0] pack_status(input wp_state_t s);
        logic [7:0] b;
        b = 8'h00;
        b[STAT_LOCK_BIT]             = s.lock;
        b[STAT_RNG_HI:STAT_RNG_LO]   = s.range;
        b[STAT_WEL_BIT]              = s.wel;
        return b;
    endfunction

endpackage

// File: rtl/wp_region_chk.sv
module wp_region_chk #(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        range,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              any_prot
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (range)
            2'b00:   hit = 1'b0;
            2'b01:   hit = addr[TOP] & addr[TOP-1];
            2'b10:   hit = addr[TOP];
            default: hit = 1'b1;
        endcase
        any_prot = |range;
    end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
    import flash_wp_pkg::*;
(
    input  logic      cmd_valid,
    input  wp_cmd_t   cmd,
    input  logic [7:0] new_status,
    input  logic      wp_n,
    input  wp_state_t cur,
    input  logic      hit,
    input  logic      any_prot,
    output wp_state_t nxt,
    output logic      acc,
    output logic      rej
);
    logic hw_lock;
    assign hw_lock = cur.lock & ~wp_n;

    always_comb begin
        nxt = cur;
        acc = 1'b0;
        rej = 1'b0;
        if (cmd_valid) begin
            unique case (cmd)
                CMD_WREN: begin
                    acc     = 1'b1;
                    nxt.wel = 1'b1;
                end
                CMD_WRDI: begin
                    acc     = 1'b1;
                    nxt.wel = 1'b0;
                end
                CMD_WRSR: begin
                    if (cur.wel && !hw_lock) begin
                        acc       = 1'b1;
                        nxt.lock  = new_status[STAT_LOCK_BIT];
                        nxt.range = new_status[STAT_RNG_HI:STAT_RNG_LO];
                    end else begin
                        rej = 1'b1;
                    end
                    nxt.wel = 1'b0;
                end
                CMD_PROG, CMD_BERS: begin
                    acc     = cur.wel & ~hit;
                    rej     = ~(cur.wel & ~hit);
                    nxt.wel = 1'b0;
                end
                CMD_CERS: begin
                    acc     = cur.wel & ~any_prot;
                    rej     = ~(cur.wel & ~any_prot);
                    nxt.wel = 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wp_state_reg.sv
module wp_state_reg
    import flash_wp_pkg::*;
#(
    parameter logic       RST_SRWD = 1'b0,
    parameter logic [1:0] RST_BP   = 2'b00
) (
    input  logic      clk,
    input  logic      rst,
    input  wp_state_t nxt,
    input  logic      acc_in,
    input  logic      rej_in,
    output wp_state_t cur,
    output logic      acc_q,
    output logic      rej_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur.lock  <= RST_SRWD;
            cur.range <= RST_BP;
            cur.wel   <= 1'b0;
            acc_q     <= 1'b0;
            rej_q     <= 1'b0;
        end else begin
            cur   <= nxt;
            acc_q <= acc_in;
            rej_q <= rej_in;
        end
    end
endmodule

// File: rtl/spi_flash_wp_ctrl.sv
module spi_flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter logic       RST_SRWD = 1'b0,
    parameter logic [1:0] RST_BP   = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [7:0]        new_status,
    input  logic [ADDR_W-1:0] addr,
    output logic              accept,
    output logic              reject,
    output logic              prot_mode,
    output logic [7:0]        status
);
    wp_state_t cur, nxt;
    logic      hit, any_prot, acc_c, rej_c;

    wp_region_chk #(.ADDR_W(ADDR_W)) i_region (
        .range    (cur.range),
        .addr     (addr),
        .hit      (hit),
        .any_prot (any_prot)
    );

    wp_gate i_gate (
        .cmd_valid  (cmd_valid),
        .cmd        (wp_cmd_t'(cmd_code)),
        .new_status (new_status),
        .wp_n       (wp_n),
        .cur        (cur),
        .hit        (hit),
        .any_prot   (any_prot),
        .nxt        (nxt),
        .acc        (acc_c),
        .rej        (rej_c)
    );

    wp_state_reg #(.RST_SRWD(RST_SRWD), .RST_BP(RST_BP)) i_state (
        .clk    (clk),
        .rst    (rst),
        .nxt    (nxt),
        .acc_in (acc_c),
        .rej_in (rej_c),
        .cur    (cur),
        .acc_q  (accept),
        .rej_q  (reject)
    );

    assign prot_mode = cur.lock & ~wp_n;
    assign status    = pack_status(cur);
endmodule

// File: rtl/spi_flash_wp_ctrl_chk.sv
module spi_flash_wp_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       accept,
    input logic       reject,
    input logic       prot_mode,
    input logic [7:0] status
);
    // R11
    one_response_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({accept, reject}));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!accept && !reject));

    // R2
    wren_sets_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd1) |=> (accept && status[1]));

    // R6
    locked_wrsr_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd3 && status[7] && !wp_n) |=> reject);

    // R6
    locked_bits_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd3 && prot_mode) |=> $stable({status[7], status[3:2]}));

    // R10
    latch_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code >= 3'd3 && cmd_code <= 3'd6) |=> !status[1]);

    // R9
    ce_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd6 && status[3:2] != 2'b00) |=> reject);

    // R12
    zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (status[6:4] == 3'b000) && !status[0]);
endmodule

bind spi_flash_wp_ctrl spi_flash_wp_ctrl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .wp_n      (wp_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .accept    (accept),
    .reject    (reject),
    .prot_mode (prot_mode),
    .status    (status)
);

// File: tb/test_spi_flash_wp_ctrl.sv
module test_spi_flash_wp_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic [7:0]  new_status = 8'h00;
    logic [15:0] addr = 16'h0000;
    logic        accept, reject, prot_mode;
    logic [7:0]  status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spi_flash_wp_ctrl i_spi_flash_wp_ctrl (
        .clk(clk), .rst(rst), .wp_n(wp_n), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .new_status(new_status), .addr(addr),
        .accept(accept), .reject(reject), .prot_mode(prot_mode), .status(status)
    );

    // {wp_n, code, new_status, addr, exp_accept, exp_reject, exp_status}
    localparam int NV = 31;
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, 3'd3, 8'h8C, 16'h0000, 1'b0, 1'b1, 8'h00}, // R3
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h02}, // R2
        {1'b1, 3'd3, 8'hF7, 16'h0000, 1'b1, 1'b0, 8'h84}, // R4 junk bits ignored
        {1'b1, 3'd4, 8'h00, 16'hFFFF, 1'b0, 1'b1, 8'h84}, // R8
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h86},
        {1'b1, 3'd4, 8'h00, 16'hC000, 1'b0, 1'b1, 8'h84}, // R7 quarter
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h86},
        {1'b1, 3'd4, 8'h00, 16'hBFFF, 1'b1, 1'b0, 8'h84}, // R7 outside
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h86},
        {1'b1, 3'd6, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h84}, // R9
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h86},
        {1'b1, 3'd5, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h84}, // R7 erase
        {1'b0, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h86},
        {1'b0, 3'd3, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h84}, // R6
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h86},
        {1'b1, 3'd3, 8'h08, 16'h0000, 1'b1, 1'b0, 8'h08}, // R4
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h0A},
        {1'b1, 3'd4, 8'h00, 16'h8000, 1'b0, 1'b1, 8'h08}, // R7 half
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h0A},
        {1'b1, 3'd4, 8'h00, 16'h7FFF, 1'b1, 1'b0, 8'h08}, // R7
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h0A},
        {1'b1, 3'd2, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h08}, // R2 disable
        {1'b0, 3'd3, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h08}, // R3
        {1'b0, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h0A},
        {1'b0, 3'd3, 8'h0C, 16'h0000, 1'b1, 1'b0, 8'h0C}, // R4 pin low, lock 0
        {1'b0, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h0E},
        {1'b0, 3'd4, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h0C}, // R7 all
        {1'b0, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h0E},
        {1'b0, 3'd3, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00}, // R10
        {1'b1, 3'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h02},
        {1'b1, 3'd6, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00}  // R9
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [7:0] d, input logic [15:0] a);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_code   = c;
        new_status = d;
        addr       = a;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status", status, 8'h00);
        check("R1 resp", {6'd0, accept, reject}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R11 idle", {6'd0, accept, reject}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            wp_n = VEC[i][37];
            issue(VEC[i][36:34], VEC[i][33:26], VEC[i][25:10]);
            check($sformatf("R11 vec%0d resp", i), {6'd0, accept, reject}, {6'd0, VEC[i][9:8]});
            check($sformatf("R12 vec%0d status", i), status, VEC[i][7:0]);
        end

        // R11: response lasts a single cycle
        @(negedge clk);
        check("R11 pulse ends", {6'd0, accept, reject}, 8'h00);

        // R11: reserved code is ignored
        wp_n = 1'b1;
        issue(3'd1, 8'h00, 16'h0);
        issue(3'd7, 8'h8C, 16'h0);
        check("R11 code7 resp", {6'd0, accept, reject}, 8'h00);
        check("R11 code7 state", status, 8'h02);

        // R8: chip erase without latch
        issue(3'd2, 8'h00, 16'h0);
        issue(3'd6, 8'h00, 16'h0);
        check("R8 ce no latch", {6'd0, accept, reject}, 8'h01);

        // R5: lock set first, then pin low
        issue(3'd1, 8'h00, 16'h0);
        issue(3'd3, 8'h80, 16'h0);
        check("R4 lock set", status, 8'h80);
        #1;
        check("R5 pin high", {7'd0, prot_mode}, 8'h00);
        @(negedge clk);
        wp_n = 1'b0;
        #1;
        check("R5 pin low after lock", {7'd0, prot_mode}, 8'h01);
        issue(3'd1, 8'h00, 16'h0);
        issue(3'd3, 8'h0C, 16'h0);
        check("R6 locked reject", {6'd0, accept, reject}, 8'h01);
        check("R6 frozen", status, 8'h80);
        @(negedge clk);
        wp_n = 1'b1;
        #1;
        check("R5 exit by pin", {7'd0, prot_mode}, 8'h00);

        // R5: pin low first, then lock set
        issue(3'd1, 8'h00, 16'h0);
        issue(3'd3, 8'h00, 16'h0);
        @(negedge clk);
        wp_n = 1'b0;
        #1;
        check("R5 pin low no lock", {7'd0, prot_mode}, 8'h00);
        issue(3'd1, 8'h00, 16'h0);
        issue(3'd3, 8'h80, 16'h0);
        #1;
        check("R5 lock after pin low", {7'd0, prot_mode}, 8'h01);
        check("R4 lock via pin low", status, 8'h80);

        finish_run();
    end
endmodule